// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter with Byte FIFO

The block sends bytes on a serial data line together with a serial clock. Software pushes bytes through a write port into a 16-entry FIFO. Whenever the transmitter is idle and the FIFO holds data, the oldest byte moves into a shift register. The byte then goes out least significant bit first: eight bits per frame, with the data changing on the falling clock edge so that a receiver can sample it on the rising edge.

The serial clock is either produced internally from a programmable half-period divider or taken from an external clock pin. The FIFO is polled again while bit 7 is on the line, so queued bytes follow one another with no idle gap. When nothing is queued, a transmit-end flag rises, the data line keeps its last level and the clock output rests high. A sticky empty-threshold flag, compared against a selectable trigger level, drives a level interrupt request through an enable input.

Top module: `sync_tx_fifo`

## Requirements
- R1: The FIFO holds 16 bytes; `level` reports the number queued. A write while `level` is 16 is dropped and leaves `level` at 16.
- R2: When idle with a non-empty FIFO, the block loads the oldest byte into the shift register at once and starts a frame. Bytes leave in write order.
- R3: Each frame is 8 bits on `txd`, bit 0 first. In internal clock mode `txd` changes only while `sclk_out` is low and holds steady across each rising edge.
- R4: In internal mode a frame is exactly 8 clock pulses. Each pulse is low for `half_div`+1 cycles, then high for `half_div`+1 cycles. `sclk_out` is high out of reset and whenever idle.
- R5: With `ext_mode`=1 the block shifts on edges of `ext_sclk`: a new bit after each falling edge and a bit boundary at each rising edge. `sclk_out` stays high.
- R6: Queued bytes are sent back to back. The rising-edge spacing stays 2×(`half_div`+1) cycles across frame boundaries, and `tx_end` does not rise between frames.
- R7: `tx_end` is 1 after reset. It is set when the FIFO is empty as bit 7 goes out, after which `txd` keeps the level of bit 7. An accepted write clears it.
- R8: `trig_sel` encodes the trigger as 0→8, 1→4, 2→2, 3→0 bytes. `thr_flag` is 1 after reset and is set whenever `level` is below the trigger (never for trigger 0).
- R9: A `flag_clr` pulse clears `thr_flag` only when `level` is at or above the trigger.
- R10: `irq` equals `thr_flag` AND `irq_en`.
- R11: A `fifo_clr` pulse empties the FIFO (`level` becomes 0). It does not abort the frame already in the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push `wr_data` into the FIFO |
| wr_data | input | 8 | Byte to queue |
| fifo_clr | input | 1 | Empty the FIFO |
| trig_sel | input | 2 | Trigger level select (0→8, 1→4, 2→2, 3→0) |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Request to clear `thr_flag` |
| ext_mode | input | 1 | 1: shift on `ext_sclk`; 0: internal clock |
| ext_sclk | input | 1 | External serial clock |
| half_div | input | DIV_W (8) | Internal half-period minus one, in `clk` cycles |
| sclk_out | output | 1 | Serial clock output |
| txd | output | 1 | Serial data output |
| level | output | clog2(DEPTH)+1 (5) | Bytes waiting in the FIFO |
| thr_flag | output | 1 | Empty-threshold flag |
| tx_end | output | 1 | Transmit-end flag |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions check several rules on every cycle. The FIFO count never exceeds its depth, and a full FIFO keeps its count against a write. Data holds steady across internal rising edges, and the clock rests high while idle. An accepted write always clears the end flag, the flag sets below the trigger, and a FIFO clear always empties the count. Other behaviour only the scenarios can show:
- the exact bit order and pulse timing per divider setting;
- gapless chaining of several frames;
- data held after the last bit;
- transmission on an external clock;
- the guarded flag clear under each trigger encoding.

// File: rtl/sync_tx_fifo.sv
module sync_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [7:0]               wr_data,
  input  logic                     fifo_clr,
  input  logic [1:0]               trig_sel,
  input  logic                     irq_en,
  input  logic                     flag_clr,
  input  logic                     ext_mode,
  input  logic                     ext_sclk,
  input  logic [DIV_W-1:0]         half_div,
  output logic                     sclk_out,
  output logic                     txd,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     thr_flag,
  output logic                     tx_end,
  output logic                     irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    rp, wp;
  logic [CW-1:0]    cnt, trig_n;
  logic             busy, lo, more;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic [DIV_W-1:0] dcnt;
  logic [2:0]       xs;

  wire push     = wr_en && (cnt != FULL) && !fifo_clr;
  wire ext_rise = xs[1] & ~xs[2];
  wire ext_fall = ~xs[1] & xs[2];
  wire tick     = ext_mode ? (lo ? ext_rise : ext_fall) : (dcnt == half_div);
  wire fall_ev  = busy & ~lo & tick;
  wire rise_ev  = busy & lo & tick;
  wire start    = !busy && (cnt != '0) && !fifo_clr;
  wire fetch    = fall_ev && (bitn == 3'd7) && (cnt != '0) && !fifo_clr;
  wire pop      = start | fetch;

  always_comb begin
    case (trig_sel)
      2'd0:    trig_n = CW'(8);
      2'd1:    trig_n = CW'(4);
      2'd2:    trig_n = CW'(2);
      default: trig_n = '0;
    endcase
  end

  always_ff @(posedge clk) if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else if (fifo_clr) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xs <= 3'b111;
    else        xs <= {xs[1:0], ext_sclk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       dcnt <= '0;
    else if (!busy || ext_mode || tick) dcnt <= '0;
    else                              dcnt <= dcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; lo <= 1'b0; more <= 1'b0; bitn <= '0;
      sh <= '0; txd <= 1'b1; tx_end <= 1'b1;
    end else begin
      if (start) begin
        sh <= mem[rp]; busy <= 1'b1; bitn <= '0; lo <= 1'b0;
      end
      if (fall_ev) begin
        lo  <= 1'b1;
        txd <= sh[0];
        sh  <= sh >> 1;
        if (bitn == 3'd7) begin
          if (fetch) begin sh <= mem[rp]; more <= 1'b1; end
          else begin more <= 1'b0; tx_end <= 1'b1; end
        end
      end
      if (rise_ev) begin
        lo <= 1'b0;
        if (bitn == 3'd7) begin
          if (more) bitn <= '0;
          else      busy <= 1'b0;
        end else bitn <= bitn + 1'b1;
      end
      if (push) tx_end <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              thr_flag <= 1'b1;
    else if (cnt < trig_n)   thr_flag <= 1'b1;
    else if (flag_clr)       thr_flag <= 1'b0;
  end

  assign sclk_out = ext_mode ? 1'b1 : ~lo;
  assign level    = cnt;
  assign irq      = thr_flag & irq_en;

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL);
  a_r1_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && wr_en && !pop && !fifo_clr) |=> (level == FULL));
  a_r3_data_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !$past(ext_mode) && $rose(sclk_out)) |-> $stable(txd));
  a_r4_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ext_mode) |-> sclk_out);
  a_r7_write_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cnt != FULL && !fifo_clr) |=> !tx_end);
  a_r8_flag_sets_below: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < trig_n) |=> thr_flag);
  a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (level == '0));
endmodule

// File: tb/sync_tx_fifo_bench.sv
`timescale 1ns/1ps
module sync_tx_fifo_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, fifo_clr = 0, irq_en = 0, flag_clr = 0, ext_mode = 0, ext_sclk = 1;
  logic [7:0] wr_data = 0, half_div = 0;
  logic [1:0] trig_sel = 0;
  logic sclk_out, txd, thr_flag, tx_end, irq;
  logic [4:0] level;

  sync_tx_fifo u_sync_tx_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fifo_clr(fifo_clr),
    .trig_sel(trig_sel), .irq_en(irq_en), .flag_clr(flag_clr), .ext_mode(ext_mode),
    .ext_sclk(ext_sclk), .half_div(half_div), .sclk_out(sclk_out), .txd(txd),
    .level(level), .thr_flag(thr_flag), .tx_end(tx_end), .irq(irq));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, ncap = 0, last_rise = -1, last_fall = -1;
  int min_int, max_int, min_lo, max_lo, ntend = 0, bad_change = 0;
  logic [127:0] capbits;
  logic p_sclk = 1, p_txd = 1, p_tend = 1;

  // monitor: reads outputs half a cycle after the edge that updates them
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!ext_mode) begin
      if (p_sclk && !sclk_out) last_fall = cyc;
      if (!p_sclk && sclk_out) begin
        if (ncap < 128) capbits[ncap] = txd;
        ncap = ncap + 1;
        if (last_rise >= 0) begin
          if (cyc - last_rise < min_int) min_int = cyc - last_rise;
          if (cyc - last_rise > max_int) max_int = cyc - last_rise;
        end
        if (cyc - last_fall < min_lo) min_lo = cyc - last_fall;
        if (cyc - last_fall > max_lo) max_lo = cyc - last_fall;
        last_rise = cyc;
      end
      if (p_sclk && sclk_out && txd != p_txd) bad_change = bad_change + 1;
    end
    if (tx_end && !p_tend) ntend = ntend + 1;
    p_sclk = sclk_out; p_txd = txd; p_tend = tx_end;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    @(posedge clk); #1;
    ncap = 0; last_rise = -1; last_fall = cyc; capbits = '0;
    min_int = 1 << 30; max_int = 0; min_lo = 1 << 30; max_lo = 0;
    ntend = 0; bad_change = 0;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_end(input int lim);
    int n = 0;
    while (!tx_end && n < lim) begin @(negedge clk); n++; end
    chk(tx_end, "R7 tx_end timeout", tx_end, 1);
  endtask

  logic [7:0] extcap;
  int ext_bad = 0;
  task automatic ext_pulses();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); ext_sclk = 0;
      repeat (6) begin @(negedge clk); if (!sclk_out) ext_bad++; end
      extcap[i] = txd;
      ext_sclk = 1;
      repeat (6) begin @(negedge clk); if (!sclk_out) ext_bad++; end
    end
  endtask

  // vector: {data, half_div, expected resting txd}
  localparam int NV = 6;
  localparam logic [16:0] VEC [NV] = '{
    {8'hA5, 8'd0, 1'b1}, {8'h35, 8'd1, 1'b0}, {8'h01, 8'd2, 1'b0},
    {8'h80, 8'd0, 1'b1}, {8'hFF, 8'd3, 1'b1}, {8'h00, 8'd1, 1'b0}};

  initial begin
    #10000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] bytes10 [10];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(sclk_out == 1, "R4 reset sclk", sclk_out, 1);
    chk(tx_end == 1, "R7 reset tx_end", tx_end, 1);
    chk(thr_flag == 1, "R8 reset flag", thr_flag, 1);
    chk(level == 0, "R1 reset level", level, 0);
    chk(irq == 0, "R10 irq off", irq, 0);
    chk(txd == 1, "R7 reset txd", txd, 1);

    // single frames from the vector table
    for (int v = 0; v < NV; v++) begin
      logic [7:0] d, dv;
      d = VEC[v][16:9]; dv = VEC[v][8:1];
      half_div = dv;
      clear_stats();
      put(d);
      wait_end(2000);
      repeat (int'(dv) + 5) @(negedge clk);
      chk(ncap == 8, "R4 pulse count", ncap, 8);
      chk(capbits[7:0] == d, "R2 R3 captured byte", capbits[7:0], d);
      chk(min_int == 2*(dv+1) && max_int == 2*(dv+1), "R4 period", max_int, 2*(dv+1));
      chk(min_lo == dv+1 && max_lo == dv+1, "R4 low phase", max_lo, dv+1);
      chk(bad_change == 0, "R3 data change while high", bad_change, 0);
      chk(sclk_out == 1 && txd == VEC[v][0], "R7 rest level", {sclk_out, txd}, {1'b1, VEC[v][0]});
    end

    // back-to-back frames
    half_div = 1;
    clear_stats();
    @(negedge clk); wr_en = 1; wr_data = 8'h3C;
    @(negedge clk); wr_data = 8'hC3;
    @(negedge clk); wr_data = 8'h5A;
    @(negedge clk); wr_en = 0;
    wait_end(2000);
    repeat (8) @(negedge clk);
    chk(ncap == 24, "R6 pulse count", ncap, 24);
    chk(capbits[23:0] == 24'h5AC33C, "R6 R2 order", capbits[23:0], 24'h5AC33C);
    chk(min_int == 4 && max_int == 4, "R6 no gap", max_int, 4);
    chk(ntend == 1, "R6 tx_end once", ntend, 1);

    // threshold flag, interrupt and full FIFO (external mode, no clock edges yet)
    ext_mode = 1; trig_sel = 2'd1; irq_en = 1;
    @(negedge clk);
    chk(thr_flag == 1 && irq == 1, "R10 irq follows flag", irq, 1);
    irq_en = 0;
    @(negedge clk);
    chk(irq == 0, "R10 irq masked", irq, 0);
    irq_en = 1;
    flag_clr = 1; @(negedge clk); flag_clr = 0; @(negedge clk);
    chk(thr_flag == 1, "R9 clear refused below trigger", thr_flag, 1);
    put(8'h96); put(8'h11); put(8'h22); put(8'h33); put(8'h44); put(8'h55);
    chk(level == 5, "R2 first byte loaded", level, 5);
    chk(tx_end == 0, "R7 write clears end", tx_end, 0);
    flag_clr = 1; @(negedge clk); flag_clr = 0; @(negedge clk);
    chk(thr_flag == 0 && irq == 0, "R9 clear accepted", {thr_flag, irq}, 0);
    trig_sel = 2'd2; @(negedge clk); @(negedge clk);
    chk(thr_flag == 0, "R8 trigger 2 not below", thr_flag, 0);
    trig_sel = 2'd0; @(negedge clk); @(negedge clk);
    chk(thr_flag == 1, "R8 trigger 8 sets", thr_flag, 1);
    trig_sel = 2'd3;
    flag_clr = 1; @(negedge clk); flag_clr = 0; @(negedge clk);
    chk(thr_flag == 0, "R8 trigger 0 never sets", thr_flag, 0);
    for (int i = 0; i < 14; i++) put(8'(i));
    chk(level == 16, "R1 fills to 16", level, 16);
    put(8'hEE);
    chk(level == 16, "R1 write when full ignored", level, 16);

    // FIFO clear keeps current frame; external clock transmits it
    @(negedge clk); fifo_clr = 1; @(negedge clk); fifo_clr = 0;
    chk(level == 0, "R11 clear empties", level, 0);
    chk(tx_end == 0, "R11 frame not aborted", tx_end, 0);
    ext_pulses();
    repeat (6) @(negedge clk);
    chk(extcap == 8'h96, "R5 external clock byte", extcap, 8'h96);
    chk(ext_bad == 0, "R5 sclk_out held high", ext_bad, 0);
    chk(tx_end == 1 && txd == 1'b1, "R7 R11 end after frame", {tx_end, txd}, 2'b11);

    // flag rises as FIFO drains below trigger 8 during transmission
    ext_mode = 0; half_div = 0; trig_sel = 2'd0;
    clear_stats();
    for (int i = 0; i < 10; i++) bytes10[i] = 8'(8'h40 + 8'(i*7));
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin wr_en = 1; wr_data = bytes10[i]; @(negedge clk); end
    wr_en = 0; flag_clr = 1; @(negedge clk); flag_clr = 0;
    chk(thr_flag == 0, "R9 cleared at 9 queued", thr_flag, 0);
    wait_end(4000);
    repeat (6) @(negedge clk);
    chk(thr_flag == 1, "R8 set after draining", thr_flag, 1);
    chk(level == 0, "R1 drained", level, 0);
    chk(ncap == 80, "R6 ten frames", ncap, 80);
    for (int i = 0; i < 10; i++)
      chk(capbits[i*8 +: 8] == bytes10[i], "R2 order of ten", capbits[i*8 +: 8], bytes10[i]);
    chk(bad_change == 0, "R3 stable across rise", bad_change, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule